// File: doc/BRIEF.md
# Atomic Split-Access Transmit Pending Register

This block holds one transmit-pending flag for each mailbox of a 32-mailbox message controller. A CPU reaches the 32 flags over a 16-bit peripheral bus, one word half per access. The upper half covers mailboxes 31 to 16 at word offset 0x020. The lower half covers mailboxes 15 to 1 at word offset 0x022. Mailbox 0 has no flag.

Holding registers make a pair of word accesses, upper first and then lower, behave as one coherent longword. On a write pair, the upper data waits in a holding register, and both halves are applied together on the lower write. On a read pair, the upper read captures a snapshot of the lower half, and the following lower read returns that snapshot.

The CPU can only set flags, by writing ones. A flag is cleared by a cancel-request vector or by a transmit-complete pulse vector from the transmit engine. A per-mailbox transmit-configuration mask decides which flags may be set. An attempt to set a flag outside that mask is dropped and reported on an error strobe.

Top module: `txpend_split_reg`

## Requirements
- R1: While reset is high and on the cycle after it, `pend_flags`, `set_err` and `rdata` are all zero.
- R2: Flag 0 is never set, even when a lower write has bit 0 at one and `tx_cfg_mask[0]` is one. Bit 0 of every lower read is zero.
- R3: On an applied write, a one bit sets the matching flag and a zero bit leaves that flag unchanged.
- R4: An upper write (`word_sel`=0) changes no flag. The next lower write (`word_sel`=1) applies the held upper data to flags 31..16 and its own data to flags 15..0, both at the same clock edge.
- R5: A lower write that is not preceded by an upper write changes only flags 15..1.
- R6: An upper read returns flags 31..16 and snapshots flags 15..0. The next lower read returns the snapshot, even if the live flags changed in between.
- R7: A lower read that is not preceded by an upper read returns the live flags 15..0.
- R8: A one in `cancel_req` or `tx_done` clears the matching flag at the next clock edge.
- R9: When a set and a clear target the same flag in the same cycle, the flag ends up clear.
- R10: A set attempt on a flag whose `tx_cfg_mask` bit is zero leaves that flag unchanged. `set_err` is one in the cycle after that write and zero after writes with no such bit.
- R11: Read data appears on `rdata` in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Single-cycle write strobe |
| rd_stb | input | 1 | Single-cycle read strobe |
| word_sel | input | 1 | 0 = upper half (0x020), 1 = lower half (0x022) |
| wdata | input | 16 | Write data for the selected half |
| rdata | output | 16 | Registered read data |
| tx_cfg_mask | input | 32 | One per mailbox configured for transmit |
| cancel_req | input | 32 | Per-mailbox clear request |
| tx_done | input | 32 | Per-mailbox transmit-complete pulses |
| pend_flags | output | 32 | Current pending flags |
| set_err | output | 1 | Pulses one cycle after an illegal set attempt |

## Verification
Every result of this block is due exactly one clock edge after the stimulus that causes it. A lower write, a clear, or a set combined with a clear shows up on `pend_flags` after one edge. `set_err` pulses after one edge. A read strobe's data shows up on `rdata` after one edge. The driver tags each expected item with the cycle count at which it is due. The monitor compares that item on the falling edge of that cycle, so every sample sits half a period away from the edge that updates the outputs. The error strobe is also checked as low on the following cycle, which confirms that it is a single-cycle pulse.

// File: rtl/txpend_pkg.sv
package txpend_pkg;
  typedef enum logic {
    HALF_UPPER = 1'b0,
    HALF_LOWER = 1'b1
  } half_e;
endpackage

// File: rtl/txpend_wr_stage.sv
module txpend_wr_stage #(
  parameter int HALF_W = 16,
  localparam int FULL_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic              word_sel,
  input  logic [HALF_W-1:0] wdata,
  output logic [FULL_W-1:0] set_vec,
  output logic              set_fire
);
  import txpend_pkg::*;

  logic [HALF_W-1:0] hold_q;
  logic              hold_vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q     <= '0;
      hold_vld_q <= 1'b0;
    end else if (wr_stb) begin
      if (half_e'(word_sel) == HALF_UPPER) begin
        hold_q     <= wdata;
        hold_vld_q <= 1'b1;
      end else begin
        hold_vld_q <= 1'b0;
      end
    end
  end

  always_comb begin
    set_fire = wr_stb && (half_e'(word_sel) == HALF_LOWER);
    set_vec  = {(hold_vld_q ? hold_q : {HALF_W{1'b0}}), wdata};
  end

  // R4: the holding flag is raised by an upper write and dropped by a lower write
  p_hold_arm_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !word_sel) |=> hold_vld_q);
  p_hold_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && word_sel) |=> !hold_vld_q);
endmodule

// File: rtl/txpend_flag_bank.sv
module txpend_flag_bank #(
  parameter int NUM_MBOX = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                set_fire,
  input  logic [NUM_MBOX-1:0] set_vec,
  input  logic [NUM_MBOX-1:0] cfg_mask,
  input  logic [NUM_MBOX-1:0] clr_vec,
  output logic [NUM_MBOX-1:0] flags,
  output logic                err
);
  logic [NUM_MBOX-1:0] legal_set;
  logic [NUM_MBOX-1:0] illegal_set;

  always_comb begin
    legal_set   = set_fire ? (set_vec & cfg_mask) : '0;
    illegal_set = set_fire ? (set_vec & ~cfg_mask) : '0;
    legal_set[0]   = 1'b0;
    illegal_set[0] = 1'b0;
  end

  assign flags[0] = 1'b0;

  for (genvar i = 1; i < NUM_MBOX; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) flags[i] <= 1'b0;
      else     flags[i] <= (flags[i] | legal_set[i]) & ~clr_vec[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) err <= 1'b0;
    else     err <= |illegal_set;
  end

  // R3: a flag only falls when a clear asked for it
  p_set_only_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(flags) & ~flags & ~$past(clr_vec)) == '0));
  // R9 / R8: a requested clear always takes effect
  p_clear_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (clr_vec != '0) |=> ((flags & $past(clr_vec)) == '0));
  // R10: newly raised flags lie inside the configuration mask
  p_cfg_only_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags & ~$past(flags) & ~$past(cfg_mask)) == '0));
endmodule

// File: rtl/txpend_rd_stage.sv
module txpend_rd_stage #(
  parameter int HALF_W = 16,
  localparam int FULL_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_stb,
  input  logic              word_sel,
  input  logic [FULL_W-1:0] live,
  output logic [HALF_W-1:0] rdata
);
  import txpend_pkg::*;

  logic [HALF_W-1:0] snap_q;
  logic              snap_vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q     <= '0;
      snap_vld_q <= 1'b0;
      rdata      <= '0;
    end else if (rd_stb) begin
      if (half_e'(word_sel) == HALF_UPPER) begin
        rdata      <= live[FULL_W-1:HALF_W];
        snap_q     <= live[HALF_W-1:0];
        snap_vld_q <= 1'b1;
      end else begin
        rdata      <= snap_vld_q ? snap_q : live[HALF_W-1:0];
        snap_vld_q <= 1'b0;
      end
    end
  end

  // R6: a paired lower read returns the value captured by the upper read
  p_snap_pair_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !word_sel) ##1 (rd_stb && word_sel) |=> (rdata == $past(live[HALF_W-1:0], 2)));
  // R11: an upper read shows the upper flags one cycle later
  p_upper_read_r11: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !word_sel) |=> (rdata == $past(live[FULL_W-1:HALF_W])));
endmodule

// File: rtl/txpend_split_reg.sv
module txpend_split_reg #(
  parameter int HALF_W = 16,
  localparam int NUM_MBOX = 2 * HALF_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_stb,
  input  logic                rd_stb,
  input  logic                word_sel,
  input  logic [HALF_W-1:0]   wdata,
  output logic [HALF_W-1:0]   rdata,
  input  logic [NUM_MBOX-1:0] tx_cfg_mask,
  input  logic [NUM_MBOX-1:0] cancel_req,
  input  logic [NUM_MBOX-1:0] tx_done,
  output logic [NUM_MBOX-1:0] pend_flags,
  output logic                set_err
);
  logic [NUM_MBOX-1:0] set_vec;
  logic                set_fire;
  logic [NUM_MBOX-1:0] clr_vec;

  assign clr_vec = cancel_req | tx_done;

  txpend_wr_stage #(.HALF_W(HALF_W)) u_wr (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .word_sel(word_sel),
    .wdata(wdata), .set_vec(set_vec), .set_fire(set_fire)
  );

  txpend_flag_bank #(.NUM_MBOX(NUM_MBOX)) u_bank (
    .clk(clk), .rst(rst), .set_fire(set_fire), .set_vec(set_vec),
    .cfg_mask(tx_cfg_mask), .clr_vec(clr_vec), .flags(pend_flags), .err(set_err)
  );

  txpend_rd_stage #(.HALF_W(HALF_W)) u_rd (
    .clk(clk), .rst(rst), .rd_stb(rd_stb), .word_sel(word_sel),
    .live(pend_flags), .rdata(rdata)
  );

  // R4: an upper write alone leaves all flags alone
  p_upper_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !word_sel && clr_vec == '0) |=> $stable(pend_flags));
  // R2: lower reads never show a flag for mailbox 0
  p_bit0_read_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && word_sel) |=> (rdata[0] == 1'b0));
  // R1: outputs are clear right after reset
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (pend_flags == '0 && !set_err && rdata == '0));
endmodule

// File: tb/tb_txpend_split_reg.sv
module tb_txpend_split_reg;
  localparam int HW = 16;
  localparam int NW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_stb = 1'b0, rd_stb = 1'b0, word_sel = 1'b0;
  logic [HW-1:0] wdata = '0;
  logic [HW-1:0] rdata;
  logic [NW-1:0] tx_cfg_mask = '0, cancel_req = '0, tx_done = '0;
  logic [NW-1:0] pend_flags;
  logic          set_err;

  txpend_split_reg #(.HALF_W(HW)) dut (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .rd_stb(rd_stb), .word_sel(word_sel),
    .wdata(wdata), .rdata(rdata), .tx_cfg_mask(tx_cfg_mask),
    .cancel_req(cancel_req), .tx_done(tx_done), .pend_flags(pend_flags), .set_err(set_err)
  );

  always #10 clk = ~clk;

  typedef struct {
    int          due;
    int          kind;   // 0 flags, 1 rdata, 2 err
    logic [31:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int cyc = 0, total = 0, bad = 0;
  bit done_flag = 1'b0;

  // model state
  logic [NW-1:0] m_flags = '0;
  logic [HW-1:0] m_wtmp = '0, m_rtmp = '0;
  bit m_wv = 0, m_rv = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = pend_flags;
        1: act = {16'h0, rdata};
        default: act = {31'h0, set_err};
      endcase
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic push(int k, logic [31:0] e, string r);
    item_t it;
    it.due = cyc + 1; it.kind = k; it.exp = e; it.req = r;
    q.push_back(it);
  endtask

  task automatic step_end();
    @(negedge clk);
    wr_stb = 0; rd_stb = 0; cancel_req = '0; tx_done = '0;
  endtask

  task automatic do_wr(bit sel, logic [HW-1:0] d, logic [NW-1:0] cn, logic [NW-1:0] dn, string r);
    logic [NW-1:0] sv, legal, illegal;
    bit e;
    wr_stb = 1; word_sel = sel; wdata = d; cancel_req = cn; tx_done = dn;
    e = 0;
    if (!sel) begin
      m_wtmp = d; m_wv = 1;
    end else begin
      sv = {(m_wv ? m_wtmp : 16'h0), d};
      sv[0] = 1'b0;
      legal = sv & tx_cfg_mask;
      illegal = sv & ~tx_cfg_mask;
      e = (illegal != '0);
      m_flags = m_flags | legal;
      m_wv = 0;
    end
    m_flags = m_flags & ~(cn | dn);
    push(0, m_flags, r);
    push(2, {31'h0, e}, r);
    step_end();
  endtask

  task automatic do_rd(bit sel, string r);
    logic [HW-1:0] e;
    rd_stb = 1; word_sel = sel;
    if (!sel) begin
      e = m_flags[31:16]; m_rtmp = m_flags[15:0]; m_rv = 1;
    end else begin
      e = m_rv ? m_rtmp : m_flags[15:0]; m_rv = 0;
    end
    push(1, {16'h0, e}, r);
    step_end();
  endtask

  task automatic do_idle(logic [NW-1:0] cn, logic [NW-1:0] dn, string r);
    cancel_req = cn; tx_done = dn;
    m_flags = m_flags & ~(cn | dn);
    push(0, m_flags, r);
    push(2, 32'h0, r);
    step_end();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R1: reset values
    push(0, 32'h0, "R1"); push(1, 32'h0, "R1"); push(2, 32'h0, "R1");
    @(negedge clk);
    tx_cfg_mask = 32'hFFEF_FFDF;  // mailboxes 20 and 5 not configured
    do_wr(1, 16'h0003, '0, '0, "R2");        // R2, R5: bit 0 dropped, bit 1 set
    do_wr(0, 16'h8001, '0, '0, "R4");        // R4: upper write alone
    do_wr(1, 16'h0100, '0, '0, "R4");        // R4: both halves together
    do_wr(1, 16'h0000, '0, '0, "R3");        // R3: zeros keep flags
    do_wr(1, 16'h0040, '0, '0, "R5");        // R5: unpaired lower write
    do_rd(0, "R11");                          // R11: upper read
    do_idle(32'h0000_0100, '0, "R8");         // R8: cancel clears bit 8
    do_rd(1, "R6");                           // R6: snapshot returned
    do_rd(1, "R7");                           // R7: live lower value
    do_idle('0, 32'h8000_0000, "R8");         // R8: completion clears bit 31
    do_wr(1, 16'h0004, 32'h0000_0004, '0, "R9"); // R9: clear wins over set
    do_wr(1, 16'h0008, '0, 32'h0000_0048, "R9"); // R9: completion wins
    do_wr(1, 16'h0020, '0, '0, "R10");       // R10: unconfigured bit 5
    do_idle('0, '0, "R10");                   // R10: strobe drops
    do_wr(0, 16'h0010, '0, '0, "R10");
    do_wr(1, 16'h0000, '0, '0, "R10");       // R10: unconfigured bit 20
    do_wr(1, 16'h0024, '0, '0, "R10");       // R10: mixed legal and illegal
    do_rd(0, "R6");
    do_rd(1, "R2");                           // R2: bit 0 reads zero
    repeat (3) @(negedge clk);
    done_flag = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done_flag) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule